// File: doc/BRIEF.md
# Indirect Mailbox Register Window

This block is the target side of a host-to-processor mailbox. The mailbox lives inside a wide 32-bit internal address space. The host does not see that space directly. It sees only two 32-bit registers on a small config-style port: an index register and a data register. The host loads an internal address into the index register. A read or write of the data register then reaches the register at that address. The index keeps its value, so several data accesses can reuse it.

Three kinds of mailbox register are decoded behind the window:
- a message ID register,
- a response register,
- a block of six argument words at consecutive word addresses.

Writing the message ID register rings a doorbell. The doorbell is a one-cycle pulse toward the internal processor, together with the latched ID. The processor side can read and overwrite any argument word, and it posts a completion code into the response register. A typical host sequence is:
1. Clear the response register.
2. Fill the arguments.
3. Write the ID.
4. Poll the response until it is non-zero.
5. Read back the arguments.

Top module: `mbox_window_top`

## Requirements
- R1: After reset, the following are all zero: the index register, message ID, response and all six argument words. `prc_doorbell` and `hst_rvalid` are low.
- R2: A host write at host offset 0xB8 loads the index register. A host read at 0xB8 returns the index. The index is unchanged by data-register reads and writes, so repeated data accesses reach the same internal address.
- R3: Host offset 0xBC is the data register and reaches the internal address held in the index. A host read strobe in cycle N gives `hst_rvalid` high and valid `hst_rdata` in cycle N+1, for one cycle.
- R4: Internal address 0x03B10528 is the message ID register. A host data write there stores the written word on `prc_msg_id` and drives `prc_doorbell` high for exactly the cycle after the write. No other access raises the doorbell.
- R5: Internal address 0x03B10564 is the response register.
  - The encoding is: 0 means no completed reply, 1 means success.
  - A host data write stores the written word, so writing 0 clears it.
  - `prc_resp_we` stores `prc_resp_wdata`.
  - When both writes happen in the same cycle, the processor value is kept.
  - `prc_resp` always shows the current value.
- R6: Argument word k (k = 0..5) is at internal address 0x03B10998 + 4*k. The host reaches it through the data register. The processor reads it combinationally on `prc_arg_rdata` with `prc_arg_sel` = k, and writes it with `prc_arg_we`. When both sides write the same word in the same cycle, the processor value is kept. A `prc_arg_sel` of 6 or 7 reads 0 and writes nothing.
- R7: Any other internal address is unmapped: a data read returns 0 and a data write changes nothing. This includes 0x03B10998 + 24 (just past the last argument), a non-multiple-of-4 offset inside the argument block, and 0x03B1052C next to the ID register.
- R8: Host offsets other than 0xB8 and 0xBC read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_off | input | 8 | Host register offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, valid with hst_rvalid |
| hst_rvalid | output | 1 | Read data valid, one cycle after hst_rd |
| prc_doorbell | output | 1 | One-cycle pulse after a message ID write |
| prc_msg_id | output | 32 | Latched message ID |
| prc_arg_sel | input | 3 | Processor argument word select |
| prc_arg_rdata | output | 32 | Selected argument word (combinational) |
| prc_arg_we | input | 1 | Processor argument write enable |
| prc_arg_wdata | input | 32 | Processor argument write data |
| prc_resp_we | input | 1 | Processor response post enable |
| prc_resp_wdata | input | 32 | Processor response code |
| prc_resp | output | 32 | Current response register value |

## Verification
The assertions check the following on every cycle:
- the doorbell only ever follows an ID write, and the ID is latched with the written word;
- a processor response post always wins over a host write;
- argument storage holds still when nothing writes it;
- an unmapped write disturbs no register;
- read-valid only ever follows a read strobe;
- the index holds unless the host writes it, and stray host offsets read zero.

Only the bench scenarios can show that each decoded address lands on the intended word, by writing and reading back through both ports. The same applies to:
- the address boundaries just past the argument block and just beside the ID register;
- the clear-by-zero host handshake;
- the argument-word collision between the two sides.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int DW      = 32;
  localparam int OFFW    = 8;
  localparam int N_ARGS  = 6;
  localparam int SEL_W   = $clog2(N_ARGS);

  localparam logic [OFFW-1:0] OFF_INDEX = 8'hB8;
  localparam logic [OFFW-1:0] OFF_DATA  = 8'hBC;

  localparam logic [DW-1:0] ADDR_ID   = 32'h03B1_0528;
  localparam logic [DW-1:0] ADDR_RESP = 32'h03B1_0564;
  localparam logic [DW-1:0] ADDR_ARG0 = 32'h03B1_0998;
  localparam logic [DW-1:0] ARG_SPAN  = DW'(4 * N_ARGS);

  typedef enum logic [1:0] {TGT_NONE, TGT_ID, TGT_RESP, TGT_ARG} tgt_e;

  typedef struct packed {
    tgt_e             tgt;
    logic [SEL_W-1:0] slot;
  } hit_t;

  // Map an internal address onto a mailbox target and argument slot.
  // Addresses below the argument base wrap to a huge offset and miss.
  function automatic hit_t classify(logic [DW-1:0] addr);
    hit_t          h;
    logic [DW-1:0] off;
    off    = addr - ADDR_ARG0;
    h.tgt  = TGT_NONE;
    h.slot = '0;
    if (addr == ADDR_ID)        h.tgt = TGT_ID;
    else if (addr == ADDR_RESP) h.tgt = TGT_RESP;
    else if (off < ARG_SPAN && off[1:0] == 2'b00) begin
      h.tgt  = TGT_ARG;
      h.slot = off[SEL_W+1:2];
    end
    return h;
  endfunction
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int AW  = DW,
  parameter int SW  = SEL_W
) (
  input  logic [AW-1:0] index_q,
  output tgt_e          tgt,
  output logic [SW-1:0] slot
);
  hit_t hit;

  always_comb begin
    hit  = classify(index_q);
    tgt  = hit.tgt;
    slot = hit.slot;
  end
endmodule

// File: rtl/mbox_host_port.sv
module mbox_host_port
  import mbox_pkg::*;
#(
  parameter int OW  = OFFW,
  parameter int W   = DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hst_wr,
  input  logic          hst_rd,
  input  logic [OW-1:0] hst_off,
  input  logic [W-1:0]  hst_wdata,
  input  logic [W-1:0]  store_rval,
  output logic [W-1:0]  index_q,
  output logic          data_we,
  output logic [W-1:0]  hst_rdata,
  output logic          hst_rvalid
);
  logic at_index, at_data, index_we;
  logic live_q;

  assign at_index = (hst_off == OFF_INDEX);
  assign at_data  = (hst_off == OFF_DATA);
  assign index_we = hst_wr && at_index;
  assign data_we  = hst_wr && at_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q    <= '0;
      hst_rdata  <= '0;
      hst_rvalid <= 1'b0;
      live_q     <= 1'b0;
    end else begin
      live_q     <= 1'b1;
      hst_rvalid <= hst_rd;
      if (index_we) index_q <= hst_wdata;
      if (hst_rd) begin
        if (at_index)     hst_rdata <= index_q;
        else if (at_data) hst_rdata <= store_rval;
        else              hst_rdata <= '0;
      end
    end
  end

  p_rvalid_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && hst_rvalid |-> $past(hst_rd));

  p_index_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && !$past(index_we) |-> $stable(index_q));

  p_stray_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(hst_rd && !at_index && !at_data) |-> hst_rdata == '0);
endmodule

// File: rtl/mbox_store.sv
module mbox_store
  import mbox_pkg::*;
#(
  parameter int W  = DW,
  parameter int N  = N_ARGS,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tgt_e          tgt,
  input  logic [SW-1:0] slot,
  input  logic          data_we,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rval,
  output logic [W-1:0]  msg_id,
  output logic          doorbell,
  output logic [W-1:0]  resp,
  input  logic [SW-1:0] prc_arg_sel,
  input  logic          prc_arg_we,
  input  logic [W-1:0]  prc_arg_wdata,
  output logic [W-1:0]  prc_arg_rdata,
  input  logic          prc_resp_we,
  input  logic [W-1:0]  prc_resp_wdata
);
  logic [N-1:0][W-1:0] arg_q;
  logic [N-1:0]        arg_wr;
  logic                id_wr_evt, resp_host_wr, arg_host_wr, unmapped_wr;
  logic                live_q;

  assign id_wr_evt    = data_we && (tgt == TGT_ID);
  assign resp_host_wr = data_we && (tgt == TGT_RESP);
  assign arg_host_wr  = data_we && (tgt == TGT_ARG);
  assign unmapped_wr  = data_we && (tgt == TGT_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_id   <= '0;
      doorbell <= 1'b0;
      resp     <= '0;
      live_q   <= 1'b0;
    end else begin
      live_q   <= 1'b1;
      doorbell <= id_wr_evt;
      if (id_wr_evt) msg_id <= wdata;
      if (prc_resp_we)       resp <= prc_resp_wdata;
      else if (resp_host_wr) resp <= wdata;
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_arg
    logic host_hit, prc_hit;
    assign host_hit  = arg_host_wr && (slot == SW'(k));
    assign prc_hit   = prc_arg_we && (prc_arg_sel == SW'(k));
    assign arg_wr[k] = host_hit || prc_hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        arg_q[k] <= '0;
      else if (prc_hit)  arg_q[k] <= prc_arg_wdata;
      else if (host_hit) arg_q[k] <= wdata;
    end
  end

  always_comb begin
    prc_arg_rdata = '0;
    for (int k = 0; k < N; k++)
      if (prc_arg_sel == SW'(k)) prc_arg_rdata = arg_q[k];
  end

  always_comb begin
    rval = '0;
    case (tgt)
      TGT_ID:   rval = msg_id;
      TGT_RESP: rval = resp;
      TGT_ARG: begin
        for (int k = 0; k < N; k++)
          if (slot == SW'(k)) rval = arg_q[k];
      end
      default:  rval = '0;
    endcase
  end

  p_bell_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && doorbell |-> $past(id_wr_evt));

  p_msgid_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(id_wr_evt) |-> msg_id == $past(wdata));

  p_resp_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(prc_resp_we) |-> resp == $past(prc_resp_wdata));

  p_arg_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(arg_wr) == '0 |-> $stable(arg_q));

  p_unmapped_inert_r7: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(unmapped_wr && !prc_resp_we && !prc_arg_we)
    |-> $stable(msg_id) && $stable(resp) && $stable(arg_q) && !doorbell);
endmodule

// File: rtl/mbox_window_top.sv
module mbox_window_top
  import mbox_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hst_wr,
  input  logic             hst_rd,
  input  logic [OFFW-1:0]  hst_off,
  input  logic [DW-1:0]    hst_wdata,
  output logic [DW-1:0]    hst_rdata,
  output logic             hst_rvalid,
  output logic             prc_doorbell,
  output logic [DW-1:0]    prc_msg_id,
  input  logic [SEL_W-1:0] prc_arg_sel,
  output logic [DW-1:0]    prc_arg_rdata,
  input  logic             prc_arg_we,
  input  logic [DW-1:0]    prc_arg_wdata,
  input  logic             prc_resp_we,
  input  logic [DW-1:0]    prc_resp_wdata,
  output logic [DW-1:0]    prc_resp
);
  logic [DW-1:0]    index_q;
  logic [DW-1:0]    store_rval;
  logic             data_we;
  tgt_e             tgt;
  logic [SEL_W-1:0] slot;

  mbox_host_port #(.OW(OFFW), .W(DW)) u_host (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd),
    .hst_off(hst_off), .hst_wdata(hst_wdata), .store_rval(store_rval),
    .index_q(index_q), .data_we(data_we),
    .hst_rdata(hst_rdata), .hst_rvalid(hst_rvalid)
  );

  mbox_decode #(.AW(DW), .SW(SEL_W)) u_dec (
    .index_q(index_q), .tgt(tgt), .slot(slot)
  );

  mbox_store #(.W(DW), .N(N_ARGS), .SW(SEL_W)) u_store (
    .clk(clk), .rst_n(rst_n), .tgt(tgt), .slot(slot),
    .data_we(data_we), .wdata(hst_wdata), .rval(store_rval),
    .msg_id(prc_msg_id), .doorbell(prc_doorbell), .resp(prc_resp),
    .prc_arg_sel(prc_arg_sel), .prc_arg_we(prc_arg_we),
    .prc_arg_wdata(prc_arg_wdata), .prc_arg_rdata(prc_arg_rdata),
    .prc_resp_we(prc_resp_we), .prc_resp_wdata(prc_resp_wdata)
  );
endmodule

// File: tb/tb_mbox_window_top.sv
`timescale 1ns/1ps
module tb_mbox_window_top;
  localparam logic [7:0]  IDX  = 8'hB8;
  localparam logic [7:0]  DAT  = 8'hBC;
  localparam logic [31:0] A_ID = 32'h03B1_0528;
  localparam logic [31:0] A_RS = 32'h03B1_0564;
  localparam logic [31:0] A_AR = 32'h03B1_0998;

  logic clk = 0, rst_n = 0;
  logic hst_wr = 0, hst_rd = 0;
  logic [7:0] hst_off = 0;
  logic [31:0] hst_wdata = 0;
  logic [31:0] hst_rdata;
  logic hst_rvalid, prc_doorbell;
  logic [31:0] prc_msg_id, prc_arg_rdata, prc_resp;
  logic [2:0] prc_arg_sel = 0;
  logic prc_arg_we = 0, prc_resp_we = 0;
  logic [31:0] prc_arg_wdata = 0, prc_resp_wdata = 0;

  int n_run = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  mbox_window_top dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwr(logic [7:0] off, logic [31:0] d);
    @(negedge clk); hst_wr = 1; hst_off = off; hst_wdata = d;
    @(negedge clk); hst_wr = 0;
  endtask

  task automatic hrd(logic [7:0] off, logic [31:0] exp, string req);
    @(negedge clk); hst_rd = 1; hst_off = off;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk); hst_rd = 0;
  endtask

  task automatic parg(int sel, logic [31:0] exp, string req);
    @(negedge clk); prc_arg_sel = 3'(sel); #1;
    chk(req, prc_arg_rdata, exp);
  endtask

  // Scoreboard monitor: compare each read return with its queued expectation.
  always @(negedge clk) begin
    if (rst_n && hst_rvalid) begin
      if (exp_q.size() == 0) chk("R3 unexpected rvalid", 32'h1, 32'h0);
      else chk(tag_q.pop_front(), hst_rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 doorbell", 32'(prc_doorbell), 0);
    chk("R1 rvalid", 32'(hst_rvalid), 0);
    chk("R1 msg_id", prc_msg_id, 0);
    chk("R1 resp", prc_resp, 0);
    for (int k = 0; k < 6; k++) parg(k, 0, "R1 arg");
    hrd(IDX, 0, "R1 index");

    // R2 index load and readback
    hwr(IDX, A_ID);
    hrd(IDX, A_ID, "R2 index readback");

    // R4 doorbell and ID latch
    hwr(DAT, 32'h0000_000C);
    chk("R4 doorbell high", 32'(prc_doorbell), 1);
    chk("R4 msg_id", prc_msg_id, 32'h0C);
    @(negedge clk);
    chk("R4 doorbell one cycle", 32'(prc_doorbell), 0);
    hrd(DAT, 32'h0C, "R3 data read of ID");
    hrd(IDX, A_ID, "R2 index persists");

    // R6 host fills arguments, processor sees them
    for (int k = 0; k < 6; k++) begin
      hwr(IDX, A_AR + 32'(4*k));
      hwr(DAT, 32'hA000_0000 + 32'(k));
      chk("R4 no bell on arg write", 32'(prc_doorbell), 0);
    end
    for (int k = 0; k < 6; k++) parg(k, 32'hA000_0000 + 32'(k), "R6 prc arg read");
    parg(6, 0, "R6 sel out of range");

    // R6 processor updates arg 2, host reads back
    @(negedge clk); prc_arg_sel = 2; prc_arg_we = 1; prc_arg_wdata = 32'h1234_5678;
    @(negedge clk); prc_arg_we = 0;
    hwr(IDX, A_AR + 8);
    hrd(DAT, 32'h1234_5678, "R6 host sees prc arg");
    hrd(DAT, 32'h1234_5678, "R2 repeated data read");

    // R6 collision on arg 3: processor wins
    hwr(IDX, A_AR + 12);
    @(negedge clk);
    hst_wr = 1; hst_off = DAT; hst_wdata = 32'hBAD0_0003;
    prc_arg_sel = 3; prc_arg_we = 1; prc_arg_wdata = 32'h600D_0003;
    @(negedge clk); hst_wr = 0; prc_arg_we = 0;
    parg(3, 32'h600D_0003, "R6 collision prc wins");

    // R5 response handshake
    @(negedge clk); prc_resp_we = 1; prc_resp_wdata = 32'h1;
    @(negedge clk); prc_resp_we = 0;
    hwr(IDX, A_RS);
    hrd(DAT, 32'h1, "R5 success code");
    hwr(DAT, 32'h0);
    chk("R5 host clear", prc_resp, 0);
    hrd(DAT, 32'h0, "R5 clear readback");
    @(negedge clk);
    hst_wr = 1; hst_off = DAT; hst_wdata = 32'h0;
    prc_resp_we = 1; prc_resp_wdata = 32'h1;
    @(negedge clk); hst_wr = 0; prc_resp_we = 0;
    chk("R5 collision prc wins", prc_resp, 1);

    // R7 unmapped addresses
    hwr(IDX, A_ID + 4);
    hwr(DAT, 32'hDEAD_BEEF);
    chk("R7 no doorbell", 32'(prc_doorbell), 0);
    chk("R7 msg_id kept", prc_msg_id, 32'h0C);
    hrd(DAT, 0, "R7 beside ID reads zero");
    hwr(IDX, A_AR + 24);
    hwr(DAT, 32'hDEAD_0024);
    hrd(DAT, 0, "R7 past last arg");
    hwr(IDX, A_AR + 2);
    hwr(DAT, 32'hDEAD_0002);
    hrd(DAT, 0, "R7 misaligned arg");
    parg(0, 32'hA000_0000, "R7 arg0 untouched");
    parg(1, 32'hA000_0001, "R7 arg1 untouched");

    // R8 stray host offsets
    hwr(IDX, A_RS);
    hwr(8'h00, 32'h5555_5555);
    hwr(8'hC0, 32'h7777_7777);
    hrd(8'h00, 0, "R8 stray read zero");
    hrd(8'hC0, 0, "R8 stray read zero C0");
    hrd(IDX, A_RS, "R8 index untouched");
    chk("R8 resp untouched", prc_resp, 1);

    repeat (4) @(negedge clk);
    chk("R3 all reads returned", 32'(exp_q.size()), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule